// File: doc/BRIEF.md
# Debug Halt Bus-Access Watchdog

This block sits between a processor pipeline's outstanding load, store or stream transfer and the debug halt request. Its job is to guarantee that a debugger can always stop the core, even when a slave never answers. The block watches for a transfer that stays pending while a halt is requested. A transfer with no halt request may wait forever.

When a halt request coincides with a pending transfer, a cycle counter runs. If the slave completes the handshake first, the transfer retires normally. If the counter reaches the timeout, the block completes the transfer itself. A forced read still writes back whatever value is on the read-data lines in that cycle. A forced write retires without a write response. A sticky flag records that a forced completion has happened. The halt acknowledge follows one cycle after the transfer retires, or one cycle after the request when nothing is pending.

Local-memory, memory-mapped and stream transfers share the same `acc_valid`/`bus_ready` handshake here, so they are all treated the same way.

Top module: `halt_access_watchdog`

## Requirements
- R1: After synchronous active-high reset, `halt_ack` and `force_seen` are 0 and no completion is forced.
- R2: While `halt_req` is low, a pending transfer (`acc_valid` high, `bus_ready` low) is never completed, however long it waits.
- R3: Call cycle 0 the first cycle in which `halt_req` and `acc_valid` are high and `bus_ready` is low. If `bus_ready` stays low, the transfer is forced in cycle TIMEOUT: `acc_done` and `acc_forced` are both high in that cycle and in no earlier one.
- R4: In a forced read (`acc_is_read` = 1), `wb_en` is high and `wb_data` equals `bus_rdata` in the forced cycle.
- R5: In a forced write (`acc_is_read` = 0), `acc_done` is high and `wb_en` is low.
- R6: If `bus_ready` rises in or before cycle TIMEOUT, the transfer completes in that cycle with `acc_forced` low. A normal read also asserts `wb_en` with `wb_data` = `bus_rdata`. The count is cleared, so the next halted transfer again needs a full TIMEOUT cycles.
- R7: Dropping `halt_req` before expiry clears the count. After `halt_req` is reasserted, forcing takes a full TIMEOUT cycles from the new start.
- R8: `halt_ack` rises one cycle after a completion (normal or forced) that occurs while `halt_req` is high. It also rises one cycle after `halt_req` when no transfer is pending. It falls one cycle after `halt_req` drops.
- R9: `force_seen` rises in the cycle after a forced completion and stays high until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| halt_req | input | 1 | Debug halt request (level) |
| acc_valid | input | 1 | A transfer is outstanding |
| acc_is_read | input | 1 | 1 = read or stream receive, 0 = write or stream send |
| bus_ready | input | 1 | Slave completes the handshake this cycle |
| bus_rdata | input | DATA_W | Live read-data lines |
| acc_done | output | 1 | Transfer retires this cycle |
| acc_forced | output | 1 | Retirement is forced by the timeout |
| wb_en | output | 1 | Write the destination register |
| wb_data | output | DATA_W | Value for the destination register |
| halt_ack | output | 1 | Core has halted |
| force_seen | output | 1 | Sticky: a forced completion has occurred |

## Verification
A count that fails to clear or runs off by one appears directly at the ports. The forced `acc_done` pulse lands in the wrong cycle after a re-armed or repeated halt, so the bench sweeps the slave's response time and the disarm point across every cycle around the timeout. A wrong enable or data path shows as `wb_en` or `wb_data` being off in the very cycle of retirement. A bad acknowledge or sticky register shows one cycle later on `halt_ack` or `force_seen`.

// File: rtl/halt_access_watchdog.sv
module halt_access_watchdog #(
  parameter int DATA_W  = 32,
  parameter int TIMEOUT = 8192
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              halt_req,
  input  logic              acc_valid,
  input  logic              acc_is_read,
  input  logic              bus_ready,
  input  logic [DATA_W-1:0] bus_rdata,
  output logic              acc_done,
  output logic              acc_forced,
  output logic              wb_en,
  output logic [DATA_W-1:0] wb_data,
  output logic              halt_ack,
  output logic              force_seen
);

  localparam int CW = $clog2(TIMEOUT + 1);
  localparam logic [CW-1:0] LIMIT = CW'(TIMEOUT);

  logic [CW-1:0] cnt;
  logic          stalled;

  assign stalled    = halt_req && acc_valid && !bus_ready;
  assign acc_forced = stalled && (cnt == LIMIT);
  assign acc_done   = acc_valid && (bus_ready || acc_forced);
  assign wb_en      = acc_done && acc_is_read;
  assign wb_data    = bus_rdata;

  always_ff @(posedge clk) begin
    if (rst)
      cnt <= '0;
    else if (stalled && !acc_forced)
      cnt <= cnt + 1'b1;
    else
      cnt <= '0;
  end

  always_ff @(posedge clk) begin
    if (rst)
      halt_ack <= 1'b0;
    else if (!halt_req)
      halt_ack <= 1'b0;
    else if (acc_done || !acc_valid)
      halt_ack <= 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst)
      force_seen <= 1'b0;
    else if (acc_forced)
      force_seen <= 1'b1;
  end

  assert_no_force_without_halt_R2: assert property (@(posedge clk) disable iff (rst)
    !halt_req |-> !acc_forced);

  assert_count_bounded_R3: assert property (@(posedge clk) disable iff (rst)
    cnt <= LIMIT);

  assert_forced_write_no_wb_R5: assert property (@(posedge clk) disable iff (rst)
    (acc_forced && !acc_is_read) |-> (acc_done && !wb_en));

  assert_normal_not_forced_R6: assert property (@(posedge clk) disable iff (rst)
    (acc_valid && bus_ready) |-> !acc_forced);

  assert_disarm_clears_R7: assert property (@(posedge clk) disable iff (rst)
    !halt_req |=> (cnt == '0));

  assert_ack_after_done_R8: assert property (@(posedge clk) disable iff (rst)
    (halt_req && acc_done) |=> halt_ack);

  assert_ack_drops_R8: assert property (@(posedge clk) disable iff (rst)
    !halt_req |=> !halt_ack);

  assert_sticky_R9: assert property (@(posedge clk) disable iff (rst)
    force_seen |=> force_seen);

  assert_sticky_sets_R9: assert property (@(posedge clk) disable iff (rst)
    acc_forced |=> force_seen);

endmodule

// File: tb/halt_access_watchdog_tb.sv
`timescale 1ns/1ps
module halt_access_watchdog_tb;
  localparam int DW = 16;
  localparam int TO = 12;

  logic clk = 1'b0;
  logic rst, halt_req, acc_valid, acc_is_read, bus_ready;
  logic [DW-1:0] bus_rdata;
  logic acc_done, acc_forced, wb_en, halt_ack, force_seen;
  logic [DW-1:0] wb_data;

  int n_run = 0, n_fail = 0;
  logic exp_seen;

  always #2.5 clk = ~clk;

  halt_access_watchdog #(.DATA_W(DW), .TIMEOUT(TO)) u_dut (
    .clk(clk), .rst(rst), .halt_req(halt_req), .acc_valid(acc_valid),
    .acc_is_read(acc_is_read), .bus_ready(bus_ready), .bus_rdata(bus_rdata),
    .acc_done(acc_done), .acc_forced(acc_forced), .wb_en(wb_en),
    .wb_data(wb_data), .halt_ack(halt_ack), .force_seen(force_seen));

  task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic idle();
    halt_req = 0; acc_valid = 0; acc_is_read = 0; bus_ready = 0; bus_rdata = '0;
  endtask

  initial begin
    #150000;
    n_fail++;
    $display("FAIL watchdog: actual=hung expected=finished");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    idle();
    rst = 1;
    tick(); tick();
    rst = 0;
    #1;
    chk("R1 halt_ack", halt_ack, 0);
    chk("R1 force_seen", force_seen, 0);
    chk("R1 acc_forced", acc_forced, 0);
    exp_seen = 0;

    // R2: long pending access without halt is never completed
    acc_valid = 1; acc_is_read = 1;
    for (int c = 0; c < 3*TO; c++) begin
      #1;
      chk("R2 no done without halt", acc_done, 0);
      tick();
    end
    chk("R2 force_seen", force_seen, 0);
    idle(); tick();

    // R3-R6, R8, R9: sweep slave response time around timeout
    for (int d = 0; d <= TO + 3; d++) begin
      int fin;
      bit frc;
      frc = (d > TO);
      fin = frc ? TO : d;
      halt_req = 1; acc_valid = 1; acc_is_read = d[0];
      for (int c = 0; c <= fin; c++) begin
        bus_ready = (c == d);
        bus_rdata = DW'(16'hA000 + d*37 + c);
        #1;
        chk(frc ? "R3 done timing" : "R6 done timing", acc_done, (c == fin));
        chk(frc ? "R3 forced flag" : "R6 forced flag", acc_forced, (c == fin) && frc);
        if (c == fin) begin
          if (d[0]) begin
            chk(frc ? "R4 wb_en" : "R6 wb_en", wb_en, 1);
            chk(frc ? "R4 wb_data" : "R6 wb_data", wb_data, DW'(16'hA000 + d*37 + c));
          end else begin
            chk(frc ? "R5 wb_en low" : "R6 wb_en low", wb_en, 0);
          end
        end
        tick();
      end
      if (frc) exp_seen = 1;
      acc_valid = 0; bus_ready = 0;
      #1;
      chk("R8 ack after completion", halt_ack, 1);
      chk("R9 force_seen", force_seen, exp_seen);
      halt_req = 0;
      tick();
      chk("R8 ack drops", halt_ack, 0);
    end

    // R8: halt with nothing pending
    halt_req = 1; #1;
    chk("R8 ack not yet", halt_ack, 0);
    tick();
    chk("R8 ack idle halt", halt_ack, 1);
    halt_req = 0; tick();

    // R7: disarm at every point before expiry, then full timeout again
    for (int k = 1; k < TO; k++) begin
      halt_req = 1; acc_valid = 1; acc_is_read = 0;
      for (int c = 0; c < k; c++) begin
        #1; chk("R7 no early force", acc_done, 0); tick();
      end
      halt_req = 0;
      #1; chk("R7 no done while released", acc_done, 0);
      tick();
      halt_req = 1;
      for (int c = 0; c <= TO; c++) begin
        #1;
        chk("R7 full timeout after rearm", acc_forced, (c == TO));
        tick();
      end
      idle(); tick();
    end

    // R6: normal completion then new halted access needs full timeout
    halt_req = 1; acc_valid = 1; acc_is_read = 1;
    for (int c = 0; c < 5; c++) begin
      bus_ready = (c == 4);
      #1; tick();
    end
    bus_ready = 0;
    for (int c = 0; c <= TO; c++) begin
      #1;
      chk("R6 count restarts", acc_forced, (c == TO));
      tick();
    end
    idle(); tick();

    // R9/R1: sticky until reset
    chk("R9 sticky", force_seen, 1);
    rst = 1; tick(); rst = 0; #1;
    chk("R1 reset clears force_seen", force_seen, 0);
    chk("R1 reset halt_ack", halt_ack, 0);

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule